// File: doc/BRIEF.md
# Indexed Pixel Unpacker with Palette

This block converts a stream of packed framebuffer bytes into 24-bit RGB pixels, one pixel per pixel-enable cycle. A two-bit depth select chooses 1, 2, 4 or 8 bits per pixel. Each accepted byte is held in a shift window. The bits at the bottom of the window, zero-extended, form an index into a 256-entry palette. After each pixel the window moves right by the pixel depth. When the byte is used up, the block asks the memory side for the next one.

All depths share the same palette, and 1-bit mode goes through it too. Low depths therefore use only the first 2, 4 or 16 entries. Black and white, grayscale, and any gamma curve are set entirely by the values the host writes into the palette. The palette read is registered, so the RGB output and its valid flag appear exactly one clock after the pixel enable.

A three-state machine controls the window. The states are SEEK, STARVE and DRAIN.
- SEEK: the window is empty and the request output is high.
- STARVE: the window is empty and the request has already been made.
- DRAIN: the window holds pixels that have not been emitted.

The transitions are:
- fill: SEEK or STARVE to DRAIN, when a byte is accepted.
- wait: SEEK to STARVE, when no byte arrives.
- spent: DRAIN to SEEK, when the last pixel of the byte is emitted.
- pass: SEEK or STARVE back to SEEK, when a byte is accepted and its only pixel is emitted in the same cycle.

Reset enters SEEK.

Top module: `idx_pixel_unpacker`

## Requirements
- R1: The cycle after a synchronous reset, the state is SEEK. `byte_req` is 1, `rgb_vld` is 0, `underrun` is 0 and `rgb_out` is 0.
- R2: At depth code 3 (8 bpp) the whole byte is the palette index. Byte 8'h93 shows entry 147.
- R3: In sub-byte modes the pixels come from the least significant end first.
  - At depth code 2 (4 bpp), byte 8'h93 gives indices 3 then 9.
  - Depth code 1 is 2 bpp and depth code 0 is 1 bpp.
- R4: The extracted bits are zero-extended, so depth 0 uses palette entries 0 and 1 only. Those two colours are whatever the host has written there.
- R5: `rgb_out` and `rgb_vld` follow `pix_en` by exactly one clock. In a cycle after `pix_en` was low, `rgb_vld` is 0 and `rgb_out` keeps its value.
- R6: `byte_req` is high in the cycle after the last pixel of a byte is emitted. A byte presented with `byte_vld` while the window is empty is accepted. If `pix_en` is high in the same cycle, that byte's first pixel is emitted at once.
- R7: `byte_vld` is ignored while the window still holds pixels that have not been emitted.
- R8: A `pix_en` with an empty window and no `byte_vld` shows palette entry 0 and sets `underrun`. `underrun` stays set until reset.
- R9: The depth is captured when a byte is accepted. A change of `depth_sel` while that byte drains has no effect until the next byte.
- R10: Reset empties the window and discards any pixels left in it. Reset does not change the palette contents.
- R11: A palette write and a pixel lookup of the same entry in the same cycle return the old entry to the pixel path.
- R12: When `pal_we` is high, `pal_wdata` is stored at `pal_addr`. Bits 23:16 are red, 15:8 are green and 7:0 are blue, and `rgb_out` uses the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| depth_sel | input | 2 | Bits per pixel: 0=1, 1=2, 2=4, 3=8 |
| pix_en | input | 1 | Emit one pixel this cycle |
| byte_vld | input | 1 | `byte_data` holds a new framebuffer byte |
| byte_data | input | 8 | Packed pixel byte |
| byte_req | output | 1 | Next byte wanted (state SEEK) |
| pal_we | input | 1 | Palette write enable |
| pal_addr | input | 8 | Palette write entry |
| pal_wdata | input | 24 | Palette write value {R,G,B} |
| rgb_out | output | 24 | Registered pixel colour {R,G,B} |
| rgb_vld | output | 1 | `rgb_out` updated by a pixel this cycle |
| underrun | output | 1 | Sticky: a pixel was requested with no data |

## Verification
The hardest case to reach from the ports is a depth change partway through a byte. The stimulus loads a 4 bpp byte, emits one pixel, switches the select to 1 bpp, and emits again; the second pixel must still be the upper nibble. A similar sequence covers the same-cycle write and lookup of one palette entry. There the bench asserts `pal_we` on the exact cycle that the byte carrying that entry's index is accepted and emitted. It then replays the byte to show the new value arrives only afterwards. Underrun is forced by holding `pix_en` high in the cycle after a request while withholding `byte_vld`.

// File: rtl/px_pkg.sv
package px_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        DEPTH_1 = 2'd0,
        DEPTH_2 = 2'd1,
        DEPTH_4 = 2'd2,
        DEPTH_8 = 2'd3
    } depth_e;

    typedef enum logic [1:0] {
        ST_SEEK   = 2'd0,
        ST_STARVE = 2'd1,
        ST_DRAIN  = 2'd2
    } win_state_e;

endpackage

// File: rtl/px_window.sv
module px_window
    import px_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  depth_e            depth_sel,
    input  logic              pix_en,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              byte_req,
    output logic [BYTE_W-1:0] idx,
    output logic              idx_vld,
    output logic              underrun
);
    localparam int CNT_W = $clog2(BYTE_W) + 1;

    win_state_e        state, state_nx;
    logic [BYTE_W-1:0] win, src, mask;
    logic [CNT_W-1:0]  left, left_now, bits_w;
    depth_e            act_depth, use_depth;
    logic              load, emit, starve, last;

    // datapath view of the current pixel
    always_comb begin
        load      = (state != ST_DRAIN) && byte_vld;
        src       = load ? byte_data : win;
        use_depth = load ? depth_sel : act_depth;
        bits_w    = CNT_W'(1) << use_depth;
        mask      = {BYTE_W{1'b1}} >> (CNT_W'(BYTE_W) - bits_w);
        left_now  = load ? (CNT_W'(BYTE_W) >> use_depth) : left;
        emit      = pix_en && (load || (state == ST_DRAIN));
        starve    = pix_en && !emit;
        last      = emit && (left_now == CNT_W'(1));
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_SEEK;
        else     state <= state_nx;
    end

    // transitions: fill, wait, spent, pass
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SEEK, ST_STARVE: begin
                if (load) state_nx = last ? ST_SEEK : ST_DRAIN;
                else      state_nx = ST_STARVE;
            end
            ST_DRAIN: begin
                if (last) state_nx = ST_SEEK;
            end
            default: state_nx = ST_SEEK;
        endcase
    end

    // outputs
    always_comb begin
        byte_req = (state == ST_SEEK);
        idx      = emit ? (src & mask) : '0;
        idx_vld  = pix_en;
    end

    // window, counter, captured depth, sticky underrun
    always_ff @(posedge clk) begin
        if (rst) begin
            win       <= '0;
            left      <= '0;
            act_depth <= DEPTH_1;
            underrun  <= 1'b0;
        end else begin
            if (load) act_depth <= depth_sel;
            if (emit) begin
                win  <= src >> bits_w;
                left <= left_now - CNT_W'(1);
            end else if (load) begin
                win  <= src;
                left <= left_now;
            end
            if (starve) underrun <= 1'b1;
        end
    end

    // R6
    req_after_last_chk: assert property (@(posedge clk) disable iff (rst)
        last |=> byte_req);
    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);
    // R7
    drain_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN && !pix_en) |=> $stable(win));
    // R9
    depth_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |=> $stable(act_depth));
    // R6
    drain_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DRAIN) |-> (left != '0));

endmodule

// File: rtl/px_palette.sv
module px_palette
    import px_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BYTE_W-1:0] waddr,
    input  logic [3*CH_W-1:0] wdata,
    input  logic              rd_en,
    input  logic [BYTE_W-1:0] raddr,
    output logic [3*CH_W-1:0] rd_data,
    output logic              rd_vld
);
    localparam int ENTRIES = 1 << BYTE_W;
    localparam int WORD_W  = 3 * CH_W;

    logic [WORD_W-1:0] mem [ENTRIES];

    // storage is never reset
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // registered lookup: same-cycle write leaves the old word here
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else begin
            rd_vld <= rd_en;
            if (rd_en) rd_data <= mem[raddr];
        end
    end

    // R5
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_vld);
    // R5
    vld_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_vld);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_data));

endmodule

// File: rtl/idx_pixel_unpacker.sv
module idx_pixel_unpacker
    import px_pkg::*;
#(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        depth_sel,
    input  logic              pix_en,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    output logic              byte_req,
    input  logic              pal_we,
    input  logic [7:0]        pal_addr,
    input  logic [3*CH_W-1:0] pal_wdata,
    output logic [3*CH_W-1:0] rgb_out,
    output logic              rgb_vld,
    output logic              underrun
);
    logic [BYTE_W-1:0] look_idx;
    logic              look_en;

    px_window u_window (
        .clk       (clk),
        .rst       (rst),
        .depth_sel (depth_e'(depth_sel)),
        .pix_en    (pix_en),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .byte_req  (byte_req),
        .idx       (look_idx),
        .idx_vld   (look_en),
        .underrun  (underrun)
    );

    px_palette #(.CH_W(CH_W)) u_palette (
        .clk     (clk),
        .rst     (rst),
        .we      (pal_we),
        .waddr   (pal_addr),
        .wdata   (pal_wdata),
        .rd_en   (look_en),
        .raddr   (look_idx),
        .rd_data (rgb_out),
        .rd_vld  (rgb_vld)
    );

endmodule

// File: tb/idx_pixel_unpacker_bench.sv
module idx_pixel_unpacker_bench;
    localparam int CLK_T = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  depth_sel = 2'd3;
    logic        pix_en = 1'b0, byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        byte_req;
    logic        pal_we = 1'b0;
    logic [7:0]  pal_addr = '0;
    logic [23:0] pal_wdata = '0;
    logic [23:0] rgb_out;
    logic        rgb_vld, underrun;

    int n_vec = 0;
    int n_bad = 0;
    logic [23:0] pal_m [256];
    logic [23:0] exp_q [$];
    string       tag_q [$];

    idx_pixel_unpacker u_idx_pixel_unpacker (
        .clk(clk), .rst(rst), .depth_sel(depth_sel), .pix_en(pix_en),
        .byte_vld(byte_vld), .byte_data(byte_data), .byte_req(byte_req),
        .pal_we(pal_we), .pal_addr(pal_addr), .pal_wdata(pal_wdata),
        .rgb_out(rgb_out), .rgb_vld(rgb_vld), .underrun(underrun)
    );

    always #(CLK_T/2) clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic pe, input logic bv, input logic [7:0] bd);
        pix_en = pe; byte_vld = bv; byte_data = bd;
        @(posedge clk); #1;
        pix_en = 1'b0; byte_vld = 1'b0; pal_we = 1'b0;
    endtask

    task automatic want(input int i, input string tag);
        exp_q.push_back(pal_m[i]);
        tag_q.push_back(tag);
    endtask

    // full byte: first pixel together with the byte, then the rest
    task automatic feed(input logic [1:0] d, input logic [7:0] b, input string tag);
        int bits, n;
        bits = 1 << d;
        n = 8 >> d;
        depth_sel = d;
        for (int k = 0; k < n; k++) begin
            want(int'((b >> (k * bits)) & ((1 << bits) - 1)), tag);
            step(1'b1, k == 0, b);
            if (k != n - 1) chk({31'd0, byte_req}, 32'd0, "R6 no request mid-byte");
        end
        chk({31'd0, byte_req}, 32'd1, "R6 request after last pixel");
    endtask

    // scoreboard monitor
    always begin
        @(posedge clk); #2;
        if (rgb_vld === 1'b1) begin
            n_vec++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R5: actual %h expected none", rgb_out);
            end else begin
                logic [23:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rgb_out !== e) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", t, rgb_out, e);
                end
            end
        end
    end

    initial begin
        #(CLK_T * 50000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [23:0] keep;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1
        chk({31'd0, byte_req}, 32'd1, "R1 byte_req");
        chk({31'd0, rgb_vld}, 32'd0, "R1 rgb_vld");
        chk({31'd0, underrun}, 32'd0, "R1 underrun");
        chk({8'd0, rgb_out}, 32'd0, "R1 rgb_out");

        // R12 palette load {R,G,B}
        for (int i = 0; i < 256; i++) begin
            pal_m[i] = {i[7:0], ~i[7:0], i[7:0] ^ 8'h5A};
            pal_we = 1'b1; pal_addr = i[7:0]; pal_wdata = pal_m[i];
            step(1'b0, 1'b0, 8'h00);
        end

        feed(2'd3, 8'h93, "R2 8bpp entry 147");
        feed(2'd3, 8'h00, "R2 8bpp entry 0");
        feed(2'd3, 8'hFF, "R12 8bpp entry 255");
        feed(2'd2, 8'h93, "R3 4bpp lsb first");
        feed(2'd1, 8'h93, "R3 2bpp lsb first");
        feed(2'd0, 8'h93, "R3 1bpp lsb first");

        // R4: 1-bit colours are programmable
        pal_m[1] = 24'h00FF00;
        pal_we = 1'b1; pal_addr = 8'd1; pal_wdata = pal_m[1];
        step(1'b0, 1'b0, 8'h00);
        feed(2'd0, 8'hA5, "R4 1bpp uses entries 0/1");

        // R5: idle cycle holds output
        keep = pal_m[8'hA5 >> 7];
        step(1'b0, 1'b0, 8'h00);
        chk({31'd0, rgb_vld}, 32'd0, "R5 idle rgb_vld");
        chk({8'd0, rgb_out}, {8'd0, keep}, "R5 idle hold");

        // R7: byte offered mid-drain is ignored
        depth_sel = 2'd2;
        want(1, "R7");
        step(1'b1, 1'b1, 8'h21);
        step(1'b0, 1'b1, 8'hFF);
        want(2, "R7 stray byte ignored");
        step(1'b1, 1'b0, 8'h00);
        chk({31'd0, byte_req}, 32'd1, "R7 request after two pixels");

        // R9: depth change mid-byte
        want(3, "R9");
        step(1'b1, 1'b1, 8'h93);
        depth_sel = 2'd0;
        want(9, "R9 depth held for byte");
        step(1'b1, 1'b0, 8'h00);
        feed(2'd0, 8'h05, "R9 new depth at boundary");

        // R8: underrun
        want(0, "R8 underrun shows entry 0");
        step(1'b1, 1'b0, 8'h00);
        chk({31'd0, underrun}, 32'd1, "R8 underrun set");
        feed(2'd3, 8'h42, "R8 recover");
        chk({31'd0, underrun}, 32'd1, "R8 underrun sticky");

        // R10: reset discards window, keeps palette
        depth_sel = 2'd2;
        want(4, "R10 before reset");
        step(1'b1, 1'b1, 8'h54);
        rst = 1'b1;
        step(1'b0, 1'b0, 8'h00);
        rst = 1'b0;
        chk({31'd0, byte_req}, 32'd1, "R10 empty after reset");
        chk({31'd0, underrun}, 32'd0, "R10 underrun cleared");
        feed(2'd3, 8'h54, "R10 palette kept");

        // R11: same-cycle write and lookup
        depth_sel = 2'd3;
        pal_we = 1'b1; pal_addr = 8'h66; pal_wdata = 24'h123456;
        want(8'h66, "R11 old value");
        step(1'b1, 1'b1, 8'h66);
        pal_m[8'h66] = 24'h123456;
        feed(2'd3, 8'h66, "R11 new value after");

        repeat (3) step(1'b0, 1'b0, 8'h00);
        chk(exp_q.size(), 32'd0, "R5 all pixels produced");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule